// File: doc/BRIEF.md
# Prefetch-Aware Batching Request Scheduler

This block arbitrates the requests waiting in one memory channel shared by several cores. Each buffered request records the issuing thread, the target bank and row, whether it is a demand or a prefetch, and whether that thread's prefetcher was judged accurate when the request arrived. Each cycle the scheduler picks at most one request and grants it, and only to a bank that reports itself ready. The scheduler groups work into batches. When the previous batch has drained, it marks a bounded number of the oldest qualifying requests of every thread. Marked requests are served before anything else except boosted demands.

Prefetches are handled according to the accuracy of their thread. A prefetch from a thread whose prefetcher is flagged inaccurate never joins a batch, so it cannot hold back other cores inside the batch window. Demands from threads flagged as light memory users jump ahead of everything, so they are not starved behind a heavy thread's stream. Inside a batch, threads are ranked by how much work they have in their busiest bank, and the lightest thread goes first. This lets a thread's requests to different banks be issued back to back, which keeps its bank parallelism.

Top module: `pa_batch_sched`

## Requirements
- R1: Synchronous active-low reset empties the buffer. After reset `gnt_valid` is 0 and `req_ready` is 1.
- R2: At most one request is granted per cycle, and only to a bank whose `bank_ready` bit is 1. No grant is made when no buffered request targets a ready bank.
- R3: Batch formation marks, for each thread, up to MARK_CAP (default 5) of its oldest eligible requests. A marked request is granted before an unmarked one of the same boost class, and `gnt_marked` reports the mark.
- R4: Demands are always eligible for marking. A prefetch is eligible only if bit `pf_accurate[thread]` was 1 when it was accepted. An ineligible prefetch is always granted with `gnt_marked` = 0.
- R5: A new batch is formed at the clock edge where the last marked request of the current batch is granted, or at any edge where no marked request remains. A request accepted while marked requests remain stays unmarked until a later formation.
- R6: A demand from a thread whose `mem_light` bit is 1 is granted before every other request, marked ones included. A prefetch from such a thread gets no boost.
- R7: Among requests equal in boost and mark, a request whose row equals the last row granted to its bank (a row hit) wins over older requests.
- R8: Thread rank is recomputed at each batch formation. A thread with fewer marked requests in its most loaded bank ranks higher, and a tie goes to the lower thread ID. Among requests equal in boost, mark and row hit, the higher-ranked thread wins.
- R9: Among requests equal in all of the above, a demand wins over a prefetch. Otherwise the older request wins.
- R10: `req_ready` stays 1 while a buffer slot is free and drops to 0 when all DEPTH (default 32) slots hold requests. Requests offered while it is 0 are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A new request is offered this cycle |
| req_ready | output | 1 | Buffer has a free slot; request accepted when both are 1 |
| req_thread | input | TID_W | Issuing thread of the offered request |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_is_pref | input | 1 | 1 = prefetch, 0 = demand |
| pf_accurate | input | NUM_THREADS | Per-thread prefetcher accuracy flag, sampled at acceptance |
| mem_light | input | NUM_THREADS | Per-thread memory non-intensive flag |
| bank_ready | input | NUM_BANKS | Per-bank ready to take a command |
| gnt_valid | output | 1 | A request is granted this cycle |
| gnt_thread | output | TID_W | Thread of the granted request |
| gnt_bank | output | BANK_W | Bank of the granted request |
| gnt_row | output | ROW_W | Row of the granted request |
| gnt_is_pref | output | 1 | Granted request is a prefetch |
| gnt_marked | output | 1 | Granted request belonged to the current batch |

## Verification
The bench builds each scenario the same way. It parks one request so that a batch forms around it, loads the contested requests while that batch holds them back, and then opens chosen banks one at a time. This gives it exact control over which requests are marked. It tests a thread that exceeds the marking cap. A design that ignored the cap would serve all seven of that thread's requests before another thread's marked one. It also tests an inaccurate prefetch, which a design that marked all prefetches would grant first. Further scenarios cover a light thread's demand against a marked request, a row hit against an older request, a thread that is heavy in one bank against a lower-ID thread, and a demand against an older prefetch of the same thread. A wrong priority order in any of these shows up as a different sequence of granted rows. The last test fills the buffer to the exact slot count to check the full boundary.

// File: rtl/pa_sched_pkg.sv
// Package pa_sched_pkg
// Shared helpers for the batching scheduler. Assumes nothing beyond
// elaboration-time constant arguments.
package pa_sched_pkg;

    // Index width for n items, at least one bit.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pa_open_rows.sv
// Module pa_open_rows
// Holds, per bank, the row of the most recent grant and whether any grant
// has reached that bank since reset. Assumes at most one update per cycle.
module pa_open_rows #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 8,
    parameter int BANK_W    = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              upd,
    input  logic [BANK_W-1:0]                 upd_bank,
    input  logic [ROW_W-1:0]                  upd_row,
    output logic [NUM_BANKS-1:0]              open_vld,
    output logic [NUM_BANKS-1:0][ROW_W-1:0]   open_row
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Capture the granted row when the grant targets this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_vld[b] <= 1'b0;
                open_row[b] <= '0;
            end else if (upd && (upd_bank == BANK_W'(b))) begin
                open_vld[b] <= 1'b1;
                open_row[b] <= upd_row;
            end
        end
    end

endmodule

// File: rtl/pa_batch_marker.sv
// Module pa_batch_marker
// Computes which eligible entries a new batch would mark (the MARK_CAP
// oldest per thread) and the thread ranking for that batch. Ranks are
// registered when form is high. Assumes MARK_CAP <= DEPTH and that the
// age matrix is a strict total order over eligible entries.
module pa_batch_marker #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_BANKS   = 8,
    parameter int DEPTH       = 32,
    parameter int MARK_CAP    = 5,
    parameter int TID_W       = 2,
    parameter int BANK_W      = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  form,
    input  logic [DEPTH-1:0]                      elig,
    input  logic [DEPTH-1:0][TID_W-1:0]           tid,
    input  logic [DEPTH-1:0][BANK_W-1:0]          bank,
    input  logic [DEPTH-1:0][DEPTH-1:0]           older,
    output logic [DEPTH-1:0]                      mark_new,
    output logic [NUM_THREADS-1:0][TID_W-1:0]     rank
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] ahead    [DEPTH];
    logic [CNT_W-1:0] load     [NUM_THREADS];
    logic [CNT_W-1:0] bank_cnt [NUM_THREADS][NUM_BANKS];
    logic [CNT_W-1:0] thr_cnt  [NUM_THREADS];
    logic [TID_W-1:0] rank_nxt [NUM_THREADS];

    // Mark an entry when fewer than MARK_CAP older eligible same-thread entries exist.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            ahead[i] = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (elig[j] && (tid[j] == tid[i]) && older[j][i]) begin
                    ahead[i] = ahead[i] + CNT_W'(1);
                end
            end
            mark_new[i] = elig[i] && (ahead[i] < CNT_W'(MARK_CAP));
        end
    end

    // Per-thread load: marked count in the thread's busiest bank.
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            load[t] = '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                bank_cnt[t][b] = '0;
                for (int i = 0; i < DEPTH; i++) begin
                    if (mark_new[i] && (tid[i] == TID_W'(t)) && (bank[i] == BANK_W'(b))) begin
                        bank_cnt[t][b] = bank_cnt[t][b] + CNT_W'(1);
                    end
                end
                if (bank_cnt[t][b] > load[t]) begin
                    load[t] = bank_cnt[t][b];
                end
            end
        end
    end

    // Rank position: count threads that sort ahead (lighter load, or equal and lower ID).
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            rank_nxt[t] = '0;
            for (int u = 0; u < NUM_THREADS; u++) begin
                if ((u != t) && ((load[u] < load[t]) || ((load[u] == load[t]) && (u < t)))) begin
                    rank_nxt[t] = rank_nxt[t] + TID_W'(1);
                end
            end
        end
    end

    // Latch the ranking of each newly formed batch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                rank[t] <= TID_W'(t);
            end
        end else if (form) begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                rank[t] <= rank_nxt[t];
            end
        end
    end

    // Independent per-thread tally of new marks, for the cap check.
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            thr_cnt[t] = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (mark_new[i] && (tid[i] == TID_W'(t))) begin
                    thr_cnt[t] = thr_cnt[t] + CNT_W'(1);
                end
            end
        end
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_cap
        AST_MARK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            form |-> (thr_cnt[t] <= CNT_W'(MARK_CAP))); // R3
    end

endmodule

// File: rtl/pa_prio_arbiter.sv
// Module pa_prio_arbiter
// Picks the single best candidate: highest key wins, ties go to the older
// entry. Assumes the age matrix orders every pair of candidates strictly.
module pa_prio_arbiter #(
    parameter int DEPTH = 32,
    parameter int KEY_W = 6,
    parameter int IDX_W = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [DEPTH-1:0]                 cand,
    input  logic [DEPTH-1:0][KEY_W-1:0]      key,
    input  logic [DEPTH-1:0][DEPTH-1:0]      older,
    output logic [DEPTH-1:0]                 win_oh,
    output logic [IDX_W-1:0]                 win_idx,
    output logic                             win_valid
);

    logic [DEPTH-1:0] beaten;

    // An entry wins when no other candidate outranks it.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            beaten[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if ((j != i) && cand[j] &&
                    ((key[j] > key[i]) || ((key[j] == key[i]) && older[j][i]))) begin
                    beaten[i] = 1'b1;
                end
            end
            win_oh[i] = cand[i] && !beaten[i];
        end
    end

    // Encode the one-hot winner.
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (win_oh[i]) begin
                win_idx = win_idx | IDX_W'(i);
            end
        end
        win_valid = |win_oh;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_oh)); // R2

endmodule

// File: rtl/pa_batch_sched.sv
// Module pa_batch_sched
// Per-channel request buffer with prefetch-aware batch marking, thread
// ranking, row-hit preference and boosting of light threads' demands.
// One request accepted and at most one granted per cycle. Assumes the
// flag inputs are stable during the cycle they are used in.
module pa_batch_sched import pa_sched_pkg::*; #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_BANKS   = 8,
    parameter int DEPTH       = 32,
    parameter int MARK_CAP    = 5,
    parameter int ROW_W       = 8,
    localparam int TID_W      = idx_w(NUM_THREADS),
    localparam int BANK_W     = idx_w(NUM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [TID_W-1:0]       req_thread,
    input  logic [BANK_W-1:0]      req_bank,
    input  logic [ROW_W-1:0]       req_row,
    input  logic                   req_is_pref,
    input  logic [NUM_THREADS-1:0] pf_accurate,
    input  logic [NUM_THREADS-1:0] mem_light,
    input  logic [NUM_BANKS-1:0]   bank_ready,
    output logic                   gnt_valid,
    output logic [TID_W-1:0]       gnt_thread,
    output logic [BANK_W-1:0]      gnt_bank,
    output logic [ROW_W-1:0]       gnt_row,
    output logic                   gnt_is_pref,
    output logic                   gnt_marked
);

    localparam int IDX_W = idx_w(DEPTH);
    localparam int KEY_W = 3 + TID_W + 1;

    logic [DEPTH-1:0]                   v_q, mark_q, pf_q, acc_q;
    logic [DEPTH-1:0][TID_W-1:0]        tid_q;
    logic [DEPTH-1:0][BANK_W-1:0]       bank_q;
    logic [DEPTH-1:0][ROW_W-1:0]        row_q;
    logic [DEPTH-1:0][DEPTH-1:0]        older_q;

    logic [IDX_W-1:0]                   free_idx;
    logic                               accept;
    logic [DEPTH-1:0]                   ins_oh, elig, cand, boost, hit, mark_new, win_oh;
    logic [DEPTH-1:0][KEY_W-1:0]        key;
    logic [NUM_THREADS-1:0][TID_W-1:0]  rank;
    logic [NUM_BANKS-1:0]               open_vld;
    logic [NUM_BANKS-1:0][ROW_W-1:0]    open_row;
    logic [IDX_W-1:0]                   win_idx;
    logic                               win_valid, batch_form, boost_rdy;

    // Lowest free slot and acceptance of the offered request.
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!v_q[i]) begin
                free_idx = IDX_W'(i);
            end
        end
        req_ready = ~&v_q;
        accept    = req_valid && req_ready;
        for (int i = 0; i < DEPTH; i++) begin
            ins_oh[i] = accept && (free_idx == IDX_W'(i));
        end
    end

    // Per-entry classification and arbitration key.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            cand[i]  = v_q[i] && bank_ready[bank_q[i]];
            boost[i] = v_q[i] && !pf_q[i] && mem_light[tid_q[i]];
            hit[i]   = open_vld[bank_q[i]] && (open_row[bank_q[i]] == row_q[i]);
            elig[i]  = v_q[i] && !win_oh[i] && (!pf_q[i] || acc_q[i]);
            key[i]   = {boost[i], mark_q[i], hit[i], ~rank[tid_q[i]], ~pf_q[i]};
        end
        batch_form = ~|(mark_q & v_q & ~win_oh);
        boost_rdy  = |(cand & boost);
    end

    // Buffer state: insertion, retirement on grant, marking on batch formation, age order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q     <= '0;
            mark_q  <= '0;
            pf_q    <= '0;
            acc_q   <= '0;
            tid_q   <= '0;
            bank_q  <= '0;
            row_q   <= '0;
            older_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ins_oh[i]) begin
                    v_q[i]     <= 1'b1;
                    mark_q[i]  <= 1'b0;
                    pf_q[i]    <= req_is_pref;
                    acc_q[i]   <= pf_accurate[req_thread];
                    tid_q[i]   <= req_thread;
                    bank_q[i]  <= req_bank;
                    row_q[i]   <= req_row;
                    older_q[i] <= '0;
                end else begin
                    if (win_oh[i]) begin
                        v_q[i]    <= 1'b0;
                        mark_q[i] <= 1'b0;
                    end else if (batch_form) begin
                        mark_q[i] <= mark_new[i];
                    end
                    if (accept) begin
                        older_q[i][free_idx] <= v_q[i];
                    end
                end
            end
        end
    end

    pa_batch_marker #(
        .NUM_THREADS (NUM_THREADS),
        .NUM_BANKS   (NUM_BANKS),
        .DEPTH       (DEPTH),
        .MARK_CAP    (MARK_CAP),
        .TID_W       (TID_W),
        .BANK_W      (BANK_W)
    ) u_marker (
        .clk      (clk),
        .rst_n    (rst_n),
        .form     (batch_form),
        .elig     (elig),
        .tid      (tid_q),
        .bank     (bank_q),
        .older    (older_q),
        .mark_new (mark_new),
        .rank     (rank)
    );

    pa_prio_arbiter #(
        .DEPTH (DEPTH),
        .KEY_W (KEY_W),
        .IDX_W (IDX_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .cand      (cand),
        .key       (key),
        .older     (older_q),
        .win_oh    (win_oh),
        .win_idx   (win_idx),
        .win_valid (win_valid)
    );

    pa_open_rows #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W),
        .BANK_W    (BANK_W)
    ) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (win_valid),
        .upd_bank (bank_q[win_idx]),
        .upd_row  (row_q[win_idx]),
        .open_vld (open_vld),
        .open_row (open_row)
    );

    // Present the winning entry.
    always_comb begin
        gnt_valid   = win_valid;
        gnt_thread  = tid_q[win_idx];
        gnt_bank    = bank_q[win_idx];
        gnt_row     = row_q[win_idx];
        gnt_is_pref = pf_q[win_idx];
        gnt_marked  = mark_q[win_idx];
    end

    AST_GNT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> bank_ready[gnt_bank]); // R2

    AST_BOOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        boost_rdy |-> (gnt_valid && !gnt_is_pref && mem_light[gnt_thread])); // R6

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot_chk
        AST_INACC_UNMARKED: assert property (@(posedge clk) disable iff (!rst_n)
            (v_q[i] && mark_q[i] && pf_q[i]) |-> acc_q[i]); // R4
        AST_NO_MIDBATCH_MARK: assert property (@(posedge clk) disable iff (!rst_n)
            !batch_form |=> !(mark_q[i] && !$past(mark_q[i]))); // R5
    end

endmodule

// File: tb/pa_batch_sched_bench.sv
`timescale 1ns/1ps
// Bench pa_batch_sched_bench: directed scenarios that load contested
// requests behind a parked batch, then release banks and compare each
// grant against the order the requirements dictate.
module pa_batch_sched_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_thread = '0;
    logic [2:0] req_bank = '0;
    logic [7:0] req_row = '0;
    logic       req_is_pref = 1'b0;
    logic [3:0] pf_accurate = 4'b0110;
    logic [3:0] mem_light = 4'b0000;
    logic [7:0] bank_ready = '0;
    logic       gnt_valid;
    logic [1:0] gnt_thread;
    logic [2:0] gnt_bank;
    logic [7:0] gnt_row;
    logic       gnt_is_pref;
    logic       gnt_marked;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    pa_batch_sched u_pa_batch_sched (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_thread  (req_thread),
        .req_bank    (req_bank),
        .req_row     (req_row),
        .req_is_pref (req_is_pref),
        .pf_accurate (pf_accurate),
        .mem_light   (mem_light),
        .bank_ready  (bank_ready),
        .gnt_valid   (gnt_valid),
        .gnt_thread  (gnt_thread),
        .gnt_bank    (gnt_bank),
        .gnt_row     (gnt_row),
        .gnt_is_pref (gnt_is_pref),
        .gnt_marked  (gnt_marked)
    );

    task automatic check(input bit ok, input string msg);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic push(input int t, input int b, input int r, input bit pf);
        @(negedge clk);
        req_valid   = 1'b1;
        req_thread  = 2'(t);
        req_bank    = 3'(b);
        req_row     = 8'(r);
        req_is_pref = pf;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic cmp_now(input int t, input int b, input int r, input int m, input string tag);
        check(gnt_valid && gnt_thread == 2'(t) && gnt_bank == 3'(b) && gnt_row == 8'(r) && gnt_marked == 1'(m),
              $sformatf("%s: actual v=%0d t=%0d b=%0d r=%0d m=%0d expected v=1 t=%0d b=%0d r=%0d m=%0d",
                        tag, gnt_valid, gnt_thread, gnt_bank, gnt_row, gnt_marked, t, b, r, m));
    endtask

    task automatic grant(input logic [7:0] rdy, input int t, input int b, input int r, input int m, input string tag);
        @(negedge clk);
        bank_ready = rdy;
        #1 cmp_now(t, b, r, m, tag);
        @(posedge clk);
        #1 bank_ready = '0;
    endtask

    task automatic no_grant(input logic [7:0] rdy, input string tag);
        @(negedge clk);
        bank_ready = rdy;
        #1 check(!gnt_valid, $sformatf("%s: actual gnt_valid=%0d expected 0", tag, gnt_valid));
        @(posedge clk);
        #1 bank_ready = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk);
        check(!gnt_valid, $sformatf("R1 in reset: actual gnt_valid=%0d expected 0", gnt_valid));
        rst_n = 1'b1;
        @(negedge clk);
        check(!gnt_valid && req_ready,
              $sformatf("R1 after reset: actual gnt_valid=%0d req_ready=%0d expected 0/1", gnt_valid, req_ready));

        // Scenario: marking cap and tie-break rank (R3, R5, R8)
        push(1, 7, 5, 0);
        idle(3);
        for (int b = 0; b < 7; b++) push(0, b, 10 + b, 0);
        push(2, 0, 99, 0);
        no_grant(8'h00, "R2 no ready bank");
        grant(8'h80, 1, 7, 5, 1, "R5 parked batch head");
        for (int b = 0; b < 5; b++) grant(8'hFF, 0, b, 10 + b, 1, "R3 capped marks, R8 lower id on tie");
        grant(8'hFF, 2, 0, 99, 1, "R3 other thread before over-cap entries");
        grant(8'hFF, 0, 5, 15, 1, "R5 next batch marks remainder");
        grant(8'hFF, 0, 6, 16, 1, "R9 older first in same thread");

        // Scenario: inaccurate prefetch stays unmarked (R4)
        push(3, 7, 1, 0);
        idle(3);
        push(0, 1, 20, 1);
        push(1, 2, 21, 1);
        push(2, 3, 22, 0);
        grant(8'h80, 3, 7, 1, 1, "R4 parked head");
        grant(8'hFF, 1, 2, 21, 1, "R4 accurate prefetch marked");
        grant(8'hFF, 2, 3, 22, 1, "R4 demand marked");
        grant(8'hFF, 0, 1, 20, 0, "R4 inaccurate prefetch unmarked");

        // Scenario: light thread demand boosted above marked (R6)
        push(0, 1, 30, 0);
        idle(3);
        push(3, 2, 31, 0);
        push(3, 3, 32, 1);
        @(negedge clk);
        bank_ready = 8'hFF;
        mem_light  = 4'b0000;
        #1 cmp_now(0, 1, 30, 1, "R6 no boost when flag clear");
        mem_light  = 4'b1000;
        #1 cmp_now(3, 2, 31, 0, "R6 boosted demand beats marked");
        @(posedge clk);
        #1 bank_ready = '0;
        grant(8'hFF, 0, 1, 30, 1, "R6 prefetch of light thread not boosted");
        grant(8'hFF, 3, 3, 32, 0, "R6 light prefetch served last");
        mem_light = 4'b0000;

        // Scenario: row hit beats older, readiness gating (R7, R2)
        push(1, 4, 0, 0);
        idle(3);
        push(2, 5, 3, 0);
        push(2, 5, 15, 0);
        no_grant(8'h00, "R2 all banks busy");
        grant(8'h20, 2, 5, 15, 0, "R7 row hit beats older, R2 marked bank busy");
        grant(8'h20, 2, 5, 3, 0, "R7 remaining miss");
        grant(8'hFF, 1, 4, 0, 1, "R2 marked served once ready");

        // Scenario: demand beats older prefetch of same thread (R9)
        push(1, 6, 40, 0);
        idle(3);
        push(0, 3, 50, 1);
        push(0, 3, 51, 0);
        grant(8'h08, 0, 3, 51, 0, "R9 demand beats older prefetch");
        grant(8'hFF, 1, 6, 40, 1, "R3 marked before unmarked");
        grant(8'hFF, 0, 3, 50, 0, "R9 prefetch last");

        // Scenario: load-based ranking (R8)
        push(2, 7, 2, 0);
        idle(3);
        push(0, 0, 60, 0);
        push(0, 0, 61, 0);
        push(3, 1, 70, 0);
        grant(8'h80, 2, 7, 2, 1, "R8 parked head");
        grant(8'hFF, 3, 1, 70, 1, "R8 lighter busiest bank ranks first");
        grant(8'hFF, 0, 0, 60, 1, "R8 heavier thread after");
        grant(8'hFF, 0, 0, 61, 1, "R8 heavier thread older first");
        no_grant(8'hFF, "R2 empty buffer");

        // Full boundary (R10)
        for (int k = 0; k < 31; k++) push(k % 4, k % 8, k, 0);
        @(negedge clk);
        check(req_ready, $sformatf("R10 one slot left: actual req_ready=%0d expected 1", req_ready));
        push(0, 0, 200, 0);
        @(negedge clk);
        check(!req_ready, $sformatf("R10 full: actual req_ready=%0d expected 0", req_ready));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule